// File: doc/BRIEF.md
# Flash Burst-Read Address Sequencer

This block drives the word addresses of a synchronous burst read from a NOR-style flash array. A read starts with a one-cycle strobe that carries a start address and a configuration: a 3-bit length code, a wrap-disable bit, a clock-edge select and a first-access latency count. On every clock after that, the block presents one word address and raises a data-valid flag. In wrapping mode, a fixed-length burst stays inside its aligned block. In linear mode, and always for continuous bursts, the address simply counts up.

A linear burst can stall once, at the first point where it moves from the last word of a 16-word row to the next row. During the stall the WAIT output is high and data-valid is low. The stall lasts as many cycles as the start address's position inside its 4-word group, but never more than the latency count minus one. The controller is a three-state machine. The states are IDLE, BURST and STALL, and the transitions are:

- Any state to BURST on a start strobe (a restart).
- BURST to IDLE on the terminal beat.
- BURST to STALL on the first row crossing with a non-zero stall length.
- STALL to BURST when the stall count runs out.

The configuration is captured when the start strobe is sampled.

Top module: `flash_burst_seq`

## Requirements
- R1: After reset, data_valid and wait_out are 0 and word_addr is 0.
- R2: On the clock after a start strobe is sampled, word_addr equals start_addr and data_valid is 1.
- R3: With cfg_nowrap=0 and cfg_len 3'b001, 3'b010 or 3'b011 (4, 8 or 16 words), each beat increments only the low log2(length) address bits modulo the length. The upper bits keep the start address's value.
- R4: With cfg_nowrap=1, each beat increments the full address by one, crossing block boundaries. A stall can only follow a beat whose address has low four bits 4'b1111.
- R5: A burst stalls at most once. Only its first 16-word row crossing can stall.
- R6: The stall lasts min(start_addr[1:0], cfg_latency-1) cycles, and 0 when cfg_latency is 0 or 1. During the stall wait_out=1, data_valid=0, and word_addr holds the last word before the crossing.
- R7: A fixed-length burst gives exactly its length in data_valid beats, then data_valid falls to 0.
- R8: cfg_len 3'b111 and the unused codes 3'b000, 3'b100, 3'b101 and 3'b110 select continuous mode. Continuous mode is linear whatever cfg_nowrap holds, and it stops after the word at the all-ones address.
- R9: A start strobe in any state, including during a stall, ends the current burst and begins the new one on the next clock.
- R10: With cfg_fall_edge=1, the outputs change on the falling clock edge, half a cycle after the rising-edge update that rising mode shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, one cycle |
| start_addr | input | ADDR_W | First word address of the burst |
| cfg_len | input | 3 | Burst length code |
| cfg_nowrap | input | 1 | 1 = linear, 0 = wrap within the length block |
| cfg_fall_edge | input | 1 | 1 = outputs update on the falling edge |
| cfg_latency | input | LAT_W | First-access latency count, used to cap the stall |
| word_addr | output | ADDR_W | Word address presented this cycle |
| data_valid | output | 1 | Current word is a data beat |
| wait_out | output | 1 | Row-crossing stall in progress |

## Verification
The restart and the row-crossing stall can fall in the same cycle: a new start strobe arrives while the machine is in STALL. The bench provokes this with a linear burst from an address ending in 4'b1111, so the stall begins on the second cycle. It then strobes a wrapping burst exactly when wait_out is seen high. The check is that on the next cycle wait_out is 0, and that the new burst's four wrapped addresses follow with no leftover stall cycles and no extra beats.

// File: rtl/fbs_pkg.sv
`timescale 1ns/1ps
package fbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_STALL = 2'd2
    } fbs_state_e;

    typedef struct packed {
        logic       cont;
        logic [2:0] lg;
    } fbs_len_t;

    function automatic fbs_len_t decode_len(input logic [2:0] code);
        fbs_len_t r;
        r.cont = 1'b0;
        r.lg   = 3'd4;
        case (code)
            3'b001:  r.lg = 3'd2;
            3'b010:  r.lg = 3'd3;
            3'b011:  r.lg = 3'd4;
            default: r.cont = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fbs_addr_step.sv
`timescale 1ns/1ps
module fbs_addr_step #(
    parameter int ADDR_W   = 16,
    parameter int ROW_BITS = 4
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              linear,
    input  logic [2:0]        len_lg,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic              row_end
);
    logic [ADDR_W-1:0] inc;
    logic [ADDR_W-1:0] low_mask;

    always_comb begin
        inc      = cur_addr + ADDR_W'(1);
        low_mask = ~({ADDR_W{1'b1}} << len_lg);
        if (linear) begin
            nxt_addr = inc;
        end else begin
            nxt_addr = (cur_addr & ~low_mask) | (inc & low_mask);
        end
        row_end = linear && (cur_addr[ROW_BITS-1:0] == {ROW_BITS{1'b1}});
    end
endmodule

// File: rtl/fbs_stall_calc.sv
`timescale 1ns/1ps
module fbs_stall_calc #(
    parameter int LAT_W = 4
) (
    input  logic [1:0]       grp_off,
    input  logic [LAT_W-1:0] latency,
    output logic [1:0]       stall_len
);
    logic [LAT_W-1:0] cap;
    logic [LAT_W-1:0] off_ext;

    always_comb begin
        cap     = (latency == '0) ? '0 : latency - LAT_W'(1);
        off_ext = LAT_W'(grp_off);
        if (off_ext < cap) begin
            stall_len = grp_off;
        end else begin
            stall_len = cap[1:0];
        end
    end
endmodule

// File: rtl/fbs_ctrl_fsm.sv
`timescale 1ns/1ps
module fbs_ctrl_fsm
    import fbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  fbs_len_t          len_cfg,
    input  logic              nowrap,
    input  logic [1:0]        stall_len,
    input  logic [ADDR_W-1:0] nxt_addr,
    input  logic              row_end,
    output logic [ADDR_W-1:0] addr_q,
    output logic              lin_q,
    output logic [2:0]        lg_q,
    output logic              core_valid,
    output logic              core_wait
);
    fbs_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_d;
    logic [BEAT_W-1:0] beats_q, beats_d, len_q;
    logic [1:0]        cnt_q, cnt_d, slen_q, slen_d;
    logic              stalled_q, stalled_d;
    logic              cont_q, cont_d, lin_d;
    logic [2:0]        lg_d;
    logic              last_beat, advance;

    always_comb begin
        len_q     = BEAT_W'(1) << lg_q;
        last_beat = cont_q ? (addr_q == {ADDR_W{1'b1}}) : (beats_q == len_q);
    end

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        addr_d    = addr_q;
        beats_d   = beats_q;
        cnt_d     = cnt_q;
        slen_d    = slen_q;
        stalled_d = stalled_q;
        cont_d    = cont_q;
        lin_d     = lin_q;
        lg_d      = lg_q;
        advance   = 1'b0;
        if (start) begin
            state_d   = ST_BURST;
            addr_d    = start_addr;
            beats_d   = BEAT_W'(1);
            stalled_d = 1'b0;
            cont_d    = len_cfg.cont;
            lin_d     = len_cfg.cont | nowrap;
            lg_d      = len_cfg.lg;
            slen_d    = stall_len;
            cnt_d     = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_BURST: begin
                    if (last_beat) begin
                        state_d = ST_IDLE;
                    end else if (row_end && !stalled_q) begin
                        stalled_d = 1'b1;
                        if (slen_q != 2'd0) begin
                            state_d = ST_STALL;
                            cnt_d   = slen_q;
                        end else begin
                            advance = 1'b1;
                        end
                    end else begin
                        advance = 1'b1;
                    end
                end
                ST_STALL: begin
                    if (cnt_q == 2'd1) begin
                        state_d = ST_BURST;
                        advance = 1'b1;
                    end
                    cnt_d = cnt_q - 2'd1;
                end
                default: state_d = ST_IDLE;
            endcase
            if (advance) begin
                addr_d = nxt_addr;
                if (!cont_q) begin
                    beats_d = beats_q + BEAT_W'(1);
                end
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            beats_q   <= '0;
            cnt_q     <= '0;
            slen_q    <= '0;
            stalled_q <= 1'b0;
            cont_q    <= 1'b0;
            lin_q     <= 1'b1;
            lg_q      <= 3'd2;
        end else begin
            state_q   <= state_d;
            addr_q    <= addr_d;
            beats_q   <= beats_d;
            cnt_q     <= cnt_d;
            slen_q    <= slen_d;
            stalled_q <= stalled_d;
            cont_q    <= cont_d;
            lin_q     <= lin_d;
            lg_q      <= lg_d;
        end
    end

    // Outputs
    always_comb begin
        core_valid = (state_q == ST_BURST);
        core_wait  = (state_q == ST_STALL);
    end

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start) |-> (state_q == ST_BURST && addr_q == $past(start_addr))); // R2
    AST_WRAP_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && !lin_q && $past(state_q) == ST_BURST && !$past(start))
        |-> ((addr_q >> lg_q) == ($past(addr_q) >> lg_q))); // R3
    AST_STALL_AT_ROW_END: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL) |-> (addr_q[3:0] == 4'hF && lin_q)); // R4
    AST_SINGLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL && $past(state_q) == ST_BURST) |-> !$past(stalled_q)); // R5
    AST_STALL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL) |-> (cnt_q != 2'd0 && cnt_q <= slen_q)); // R6
    AST_BEAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && !cont_q) |-> (beats_q <= len_q)); // R7
endmodule

// File: rtl/fbs_edge_out.sv
`timescale 1ns/1ps
module fbs_edge_out #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_sel,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_valid,
    input  logic              in_wait,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_valid,
    output logic              out_wait
);
    logic [ADDR_W-1:0] neg_addr;
    logic              neg_valid, neg_wait;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_addr  <= '0;
            neg_valid <= 1'b0;
            neg_wait  <= 1'b0;
        end else begin
            neg_addr  <= in_addr;
            neg_valid <= in_valid;
            neg_wait  <= in_wait;
        end
    end

    always_comb begin
        if (fall_sel) begin
            out_addr  = neg_addr;
            out_valid = neg_valid;
            out_wait  = neg_wait;
        end else begin
            out_addr  = in_addr;
            out_valid = in_valid;
            out_wait  = in_wait;
        end
    end

    AST_NO_VALID_AND_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_wait)); // R6
endmodule

// File: rtl/flash_burst_seq.sv
`timescale 1ns/1ps
module flash_burst_seq
    import fbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [2:0]        cfg_len,
    input  logic              cfg_nowrap,
    input  logic              cfg_fall_edge,
    input  logic [LAT_W-1:0]  cfg_latency,
    output logic [ADDR_W-1:0] word_addr,
    output logic              data_valid,
    output logic              wait_out
);
    localparam int BEAT_W = 5;

    fbs_len_t          len_cfg;
    logic [1:0]        stall_len;
    logic [ADDR_W-1:0] addr_q, nxt_addr;
    logic              lin_q, row_end, core_valid, core_wait;
    logic [2:0]        lg_q;

    always_comb len_cfg = decode_len(cfg_len);

    fbs_stall_calc #(.LAT_W(LAT_W)) u_stall (
        .grp_off   (start_addr[1:0]),
        .latency   (cfg_latency),
        .stall_len (stall_len)
    );

    fbs_addr_step #(.ADDR_W(ADDR_W), .ROW_BITS(4)) u_step (
        .cur_addr (addr_q),
        .linear   (lin_q),
        .len_lg   (lg_q),
        .nxt_addr (nxt_addr),
        .row_end  (row_end)
    );

    fbs_ctrl_fsm #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .len_cfg    (len_cfg),
        .nowrap     (cfg_nowrap),
        .stall_len  (stall_len),
        .nxt_addr   (nxt_addr),
        .row_end    (row_end),
        .addr_q     (addr_q),
        .lin_q      (lin_q),
        .lg_q       (lg_q),
        .core_valid (core_valid),
        .core_wait  (core_wait)
    );

    fbs_edge_out #(.ADDR_W(ADDR_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_sel  (cfg_fall_edge),
        .in_addr   (addr_q),
        .in_valid  (core_valid),
        .in_wait   (core_wait),
        .out_addr  (word_addr),
        .out_valid (data_valid),
        .out_wait  (wait_out)
    );
endmodule

// File: tb/flash_burst_seq_test.sv
`timescale 1ns/1ps
module flash_burst_seq_test;
    localparam int AW = 16;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [2:0]    cfg_len = 3'b001;
    logic          cfg_nowrap = 1'b1;
    logic          cfg_fall_edge = 1'b0;
    logic [LW-1:0] cfg_latency = 4'd4;
    logic [AW-1:0] word_addr;
    logic          data_valid, wait_out;

    int n_checks = 0;
    int n_fail = 0;

    logic          ev [64];
    logic          ew [64];
    logic [AW-1:0] ea [64];

    always #2.5 clk = ~clk;

    flash_burst_seq #(.ADDR_W(AW), .LAT_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .cfg_len(cfg_len), .cfg_nowrap(cfg_nowrap), .cfg_fall_edge(cfg_fall_edge),
        .cfg_latency(cfg_latency), .word_addr(word_addr), .data_valid(data_valid),
        .wait_out(wait_out)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Called at posedge+1; returns at posedge+1 after the edge that sampled start.
    task automatic do_start(input int sa, input logic [2:0] code, input logic nw, input int lat);
        start       = 1'b1;
        start_addr  = AW'(sa);
        cfg_len     = code;
        cfg_nowrap  = nw;
        cfg_latency = LW'(lat);
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    // Expected trace built from the requirements.
    task automatic build_model(input int sa, input logic [2:0] code, input logic nw, input int lat);
        bit cont, lin, stalled;
        int n, s, nb, ptr, a, prev;
        cont = !(code == 3'b001 || code == 3'b010 || code == 3'b011);
        n    = (code == 3'b001) ? 4 : (code == 3'b010) ? 8 : 16;
        lin  = cont || nw;
        s    = (lat <= 1) ? 0 : (((sa % 4) < lat - 1) ? (sa % 4) : lat - 1);
        nb   = cont ? (65536 - sa) : n;
        for (int c = 0; c < 64; c++) begin
            ev[c] = 1'b0; ew[c] = 1'b0; ea[c] = '0;
        end
        ptr = 0; stalled = 0; prev = sa;
        for (int i = 0; i < nb && ptr < 64; i++) begin
            a = lin ? ((sa + i) & 16'hFFFF) : ((sa & ~(n - 1)) | ((sa + i) & (n - 1)));
            if (lin && i > 0 && (a % 16) == 0 && !stalled) begin
                stalled = 1;
                for (int k = 0; k < s && ptr < 64; k++) begin
                    ew[ptr] = 1'b1; ea[ptr] = AW'(prev); ptr++;
                end
            end
            if (ptr < 64) begin
                ev[ptr] = 1'b1; ea[ptr] = AW'(a); ptr++;
            end
            prev = a;
        end
    endtask

    task automatic run_burst(input string tag, input int sa, input logic [2:0] code,
                             input logic nw, input int lat, input int ncyc);
        build_model(sa, code, nw, lat);
        do_start(sa, code, nw, lat);
        for (int c = 0; c < ncyc; c++) begin
            chk(tag, $sformatf("valid c%0d", c), 32'(data_valid), 32'(ev[c]));
            chk(tag, $sformatf("wait c%0d", c), 32'(wait_out), 32'(ew[c]));
            if (ev[c] || ew[c]) chk(tag, $sformatf("addr c%0d", c), 32'(word_addr), 32'(ea[c]));
            @(posedge clk); #1;
        end
    endtask

    task automatic t_reset;
        chk("R1", "reset valid", 32'(data_valid), 0);
        chk("R1", "reset wait", 32'(wait_out), 0);
        chk("R1", "reset addr", 32'(word_addr), 0);
    endtask

    task automatic t_wrap;
        run_burst("R3 R7 len4", 16'h0106, 3'b001, 1'b0, 4, 7);
        run_burst("R3 R7 len8", 16'h0205, 3'b010, 1'b0, 4, 10);
        run_burst("R3 R7 len16", 16'h003E, 3'b011, 1'b0, 4, 18);
    endtask

    task automatic t_linear;
        run_burst("R4 R2 aligned", 16'h000C, 3'b010, 1'b1, 5, 10);
        run_burst("R6 off2", 16'h000E, 3'b010, 1'b1, 5, 12);
        run_burst("R6 off3", 16'h000F, 3'b001, 1'b1, 6, 9);
        run_burst("R6 cap", 16'h000F, 3'b001, 1'b1, 2, 7);
        run_burst("R6 lat1", 16'h001E, 3'b001, 1'b1, 1, 6);
    endtask

    task automatic t_continuous;
        run_burst("R5 R8 cont", 16'h001D, 3'b111, 1'b0, 8, 40);
        run_burst("R8 reserved end", 16'hFFFB, 3'b100, 1'b0, 8, 8);
    endtask

    // Restart arriving while the stall is in progress.
    task automatic t_restart;
        do_start(16'h000F, 3'b001, 1'b1, 6);
        @(posedge clk); #1;
        chk("R9", "stall seen before restart", 32'(wait_out), 1);
        run_burst("R9 restart", 16'h0042, 3'b001, 1'b0, 6, 7);
    endtask

    task automatic t_fall;
        cfg_fall_edge = 1'b1;
        do_start(16'h0050, 3'b001, 1'b1, 4);
        chk("R10", "no change at rising edge", 32'(data_valid), 0);
        #2.5;
        chk("R10", "valid after falling edge", 32'(data_valid), 1);
        chk("R10", "addr after falling edge", 32'(word_addr), 32'h50);
        #2.5;
        chk("R10", "addr held past rising edge", 32'(word_addr), 32'h50);
        #2.5;
        chk("R10", "addr next after falling edge", 32'(word_addr), 32'h51);
        #2.5;
        repeat (5) @(posedge clk);
        #1;
        cfg_fall_edge = 1'b0;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_wrap();
        t_linear();
        t_continuous();
        t_restart();
        t_fall();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #900000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule